// File: doc/BRIEF.md
# Instruction Slice Gating Tracker

The block follows one class of instruction as it moves through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It does this by passing a one-bit presence token from stage to stage. A new token starts in the fetch stage when the fetched word carries the selected primary opcode, provided the pipeline is neither flushed nor frozen at fetch. Each later stage registers the token of the stage before it, unless its own freeze input is active. The per-stage tokens drive active-high gating enables.

While a stage's enable is high, logic in that stage that the tracked instruction does not use may be switched off for that cycle. The gating does not change architectural behaviour. The opcode value and the mask that selects the compared bits are parameters, so one instance can track any primary-opcode class.

Top module: `slice_gate_tracker`

## Requirements
- R1: When `rst_n` goes low, every token and every gating enable goes to 0 at once, without waiting for a clock edge. They stay 0 while `rst_n` is held low.
- R2: Suppose that in a cycle the field `instr_word[31:26]` equals 6'b111000, `flush` is low and `stage_freeze[0]` is low. Then `slice_token[0]` is 1 after the next rising edge. In every other case it is 0 after that edge.
- R3: If `flush` is high in a cycle where the opcode matches, no fetch token is produced by that cycle.
- R4: `stage_freeze` bit s qualifies only stage s (bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback). If bit s is high in a cycle, `slice_token[s]` is 0 after the next edge. The other stages are unaffected.
- R5: For stages 1 to 4, after each rising edge `slice_token[s]` equals the previous cycle's `slice_token[s-1]` ANDed with the inverse of that cycle's `stage_freeze[s]`.
- R6: Matching instructions fetched in back-to-back cycles produce tokens in adjacent stages at the same time. Five consecutive unfrozen matches set all five tokens.
- R7: `gate_en` equals `slice_token` bit for bit in every cycle.
- R8: Bits of `instr_word` outside [31:26] have no effect. An opcode field that differs from 6'b111000 in any single bit produces no token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| instr_word | input | 32 | Instruction word fetched this cycle |
| flush | input | 1 | Pipeline flush; blocks a new fetch token |
| stage_freeze | input | 5 | Per-stage freeze, bit 0 fetch to bit 4 writeback |
| slice_token | output | 5 | Registered presence token per stage |
| gate_en | output | 5 | Active-high per-stage gating enable |

## Verification
The bench builds the block with its default parameters: five stages, opcode 6'b111000 and a full six-bit mask. With these values the whole state is a five-bit vector, and the bench can model it exactly with a shift of the inputs it has applied.

A long pseudo-random run mixes matching and non-matching words, occasional flushes and independent freezes in every stage. This covers a large share of the token and freeze combinations. Directed sequences add the remaining cases:
- back-to-back matches that fill the pipe;
- a freeze in each single stage while the pipe is full;
- a flush in the same cycle as a match;
- single-bit opcode neighbours;
- an asynchronous reset in the middle of a cycle.

// File: rtl/slice_gate_pkg.sv
package slice_gate_pkg;
  localparam int unsigned PIPE_STAGES = 5;
  localparam int unsigned OPC_BITS    = 6;

  typedef enum logic [2:0] {
    STG_FETCH  = 3'd0,
    STG_DECODE = 3'd1,
    STG_EXEC   = 3'd2,
    STG_MEMORY = 3'd3,
    STG_WBACK  = 3'd4
  } stage_e;
endpackage

// File: rtl/slice_opc_match.sv
module slice_opc_match #(
  parameter int unsigned           OPC_W     = 6,
  parameter logic [OPC_W-1:0]      MATCH_OPC = 6'b111000,
  parameter logic [OPC_W-1:0]      OPC_MASK  = 6'b111111
) (
  input  logic [OPC_W-1:0] opcode,
  output logic             hit
);
  localparam logic [OPC_W-1:0] MASKED_REF = MATCH_OPC & OPC_MASK;

  always_comb begin
    hit = ((opcode & OPC_MASK) == MASKED_REF);
  end
endmodule

// File: rtl/slice_token_reg.sv
module slice_token_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_in,
  input  logic block,
  output logic tok_q
);
  logic tok_d;

  // next-state: token advances unless this stage is held off
  always_comb begin
    tok_d = tok_in & ~block;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= 1'b0;
    end else begin
      tok_q <= tok_d;
    end
  end
endmodule

// File: rtl/slice_gate_tracker.sv
module slice_gate_tracker
  import slice_gate_pkg::*;
#(
  parameter int unsigned                 NUM_STAGES = PIPE_STAGES,
  parameter int unsigned                 INSTR_W    = 32,
  parameter int unsigned                 OPC_MSB    = 31,
  parameter int unsigned                 OPC_W      = OPC_BITS,
  parameter logic [OPC_W-1:0]            MATCH_OPC  = 6'b111000,
  parameter logic [OPC_W-1:0]            OPC_MASK   = 6'b111111
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INSTR_W-1:0]    instr_word,
  input  logic                  flush,
  input  logic [NUM_STAGES-1:0] stage_freeze,
  output logic [NUM_STAGES-1:0] slice_token,
  output logic [NUM_STAGES-1:0] gate_en
);
  localparam int unsigned OPC_LSB = OPC_MSB - OPC_W + 1;

  logic                  opc_hit;
  logic [NUM_STAGES-1:0] stage_in;
  logic [NUM_STAGES-1:0] stage_block;

  slice_opc_match #(
    .OPC_W     (OPC_W),
    .MATCH_OPC (MATCH_OPC),
    .OPC_MASK  (OPC_MASK)
  ) u_match (
    .opcode (instr_word[OPC_MSB:OPC_LSB]),
    .hit    (opc_hit)
  );

  genvar s;
  generate
    for (s = 0; s < NUM_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_comb begin
          stage_in[s]    = opc_hit;
          stage_block[s] = stage_freeze[s] | flush;
        end
      end else begin : g_body
        always_comb begin
          stage_in[s]    = slice_token[s-1];
          stage_block[s] = stage_freeze[s];
        end
      end

      slice_token_reg u_tok (
        .clk    (clk),
        .rst_n  (rst_n),
        .tok_in (stage_in[s]),
        .block  (stage_block[s]),
        .tok_q  (slice_token[s])
      );

      always_comb begin
        gate_en[s] = slice_token[s];
      end
    end
  endgenerate
endmodule

// File: rtl/slice_gate_tracker_chk.sv
module slice_gate_tracker_chk #(
  parameter int unsigned      NUM_STAGES = 5,
  parameter int unsigned      INSTR_W    = 32,
  parameter int unsigned      OPC_MSB    = 31,
  parameter int unsigned      OPC_W      = 6,
  parameter logic [OPC_W-1:0] MATCH_OPC  = 6'b111000,
  parameter logic [OPC_W-1:0] OPC_MASK   = 6'b111111
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [INSTR_W-1:0]    instr_word,
  input logic                  flush,
  input logic [NUM_STAGES-1:0] stage_freeze,
  input logic [NUM_STAGES-1:0] slice_token,
  input logic [NUM_STAGES-1:0] gate_en
);
  localparam int unsigned OPC_LSB = OPC_MSB - OPC_W + 1;

  logic fetch_ok;
  always_comb begin
    fetch_ok = ((instr_word[OPC_MSB:OPC_LSB] & OPC_MASK) == (MATCH_OPC & OPC_MASK))
               && !flush && !stage_freeze[0];
  end

  AST_FETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ok |=> slice_token[0]); // R2
  AST_FETCH_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ok |=> !slice_token[0]); // R2
  AST_FLUSH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !slice_token[0]); // R3
  AST_GATE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en == slice_token); // R7

  genvar s;
  generate
    for (s = 0; s < NUM_STAGES; s++) begin : g_chk
      AST_FREEZE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        stage_freeze[s] |=> !slice_token[s]); // R4
      if (s > 0) begin : g_shift
        AST_TOKEN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
          (slice_token[s-1] && !stage_freeze[s]) |=> slice_token[s]); // R5
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
          !slice_token[s-1] |=> !slice_token[s]); // R5
      end
    end
  endgenerate
endmodule

bind slice_gate_tracker slice_gate_tracker_chk #(
  .NUM_STAGES (NUM_STAGES),
  .INSTR_W    (INSTR_W),
  .OPC_MSB    (OPC_MSB),
  .OPC_W      (OPC_W),
  .MATCH_OPC  (MATCH_OPC),
  .OPC_MASK   (OPC_MASK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .instr_word   (instr_word),
  .flush        (flush),
  .stage_freeze (stage_freeze),
  .slice_token  (slice_token),
  .gate_en      (gate_en)
);

// File: tb/slice_gate_tracker_tb.sv
`timescale 1ns/1ps
module slice_gate_tracker_tb;
  localparam int NS = 5;
  localparam logic [5:0] OPC = 6'b111000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   instr_word;
  logic          flush;
  logic [NS-1:0] stage_freeze;
  logic [NS-1:0] slice_token;
  logic [NS-1:0] gate_en;

  logic [NS-1:0] exp_tok;
  logic [15:0]   lfsr;
  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  slice_gate_tracker u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_word   (instr_word),
    .flush        (flush),
    .stage_freeze (stage_freeze),
    .slice_token  (slice_token),
    .gate_en      (gate_en)
  );

  task automatic check(input string req);
    n_chk++;
    if (slice_token !== exp_tok) begin
      n_fail++;
      $display("FAIL %s token actual=%b expected=%b t=%0t", req, slice_token, exp_tok, $time);
    end
    n_chk++;
    if (gate_en !== exp_tok) begin
      n_fail++;
      $display("FAIL R7 gate_en (%s) actual=%b expected=%b t=%0t", req, gate_en, exp_tok, $time);
    end
  endtask

  // drive inputs, clock once, update reference shift model, check
  task automatic step(input logic [31:0] iw, input logic fl, input logic [NS-1:0] fz,
                      input string req);
    logic [NS-1:0] nxt;
    instr_word   = iw;
    flush        = fl;
    stage_freeze = fz;
    @(posedge clk);
    if (!rst_n) nxt = '0;
    else begin
      nxt[0] = (iw[31:26] == OPC) && !fl && !fz[0];
      for (int s = 1; s < NS; s++) nxt[s] = exp_tok[s-1] && !fz[s];
    end
    exp_tok = nxt;
    #1;
    check(req);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] low);
    return {op, low};
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    exp_tok = '0;
    instr_word = '0; flush = 1'b0; stage_freeze = '0;
    // R1: held in reset with matching words
    for (int i = 0; i < 4; i++) step(mk(OPC, 26'h1234), 1'b0, '0, "R1");
    #1 rst_n = 1'b1;

    // R6: back-to-back matches fill the pipe
    for (int i = 0; i < NS; i++) step(mk(OPC, 26'(i * 777)), 1'b0, '0, "R6");
    n_chk++;
    if (slice_token !== 5'b11111) begin
      n_fail++;
      $display("FAIL R6 full pipe actual=%b expected=11111", slice_token);
    end

    // R4: freeze each stage once with the pipe full
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < NS; i++) step(mk(OPC, 26'h0), 1'b0, '0, "R6");
      step(mk(OPC, 26'h3ff), 1'b0, NS'(1 << s), "R4");
      step(mk(6'b000000, 26'h0), 1'b0, '0, "R5");
    end

    // R3: flush together with a match
    for (int i = 0; i < NS; i++) step(mk(OPC, 26'h0), 1'b0, '0, "R6");
    step(mk(OPC, 26'h2aaaaaa), 1'b1, '0, "R3");
    step(mk(OPC, 26'h0), 1'b1, 5'b11110, "R3");
    for (int i = 0; i < NS; i++) step(mk(6'b010101, 26'h0), 1'b0, '0, "R5");

    // R8: low bits ignored, single-bit opcode neighbours rejected
    step(mk(OPC, 26'h3ffffff), 1'b0, '0, "R8");
    step(mk(OPC, 26'h0000000), 1'b0, '0, "R8");
    for (int b = 0; b < 6; b++) step(mk(OPC ^ 6'(1 << b), 26'h3ffffff), 1'b0, '0, "R8");

    // R2/R5: pseudo-random sweep
    lfsr = 16'hace1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(mk((lfsr[1:0] != 2'b00) ? OPC : lfsr[7:2], {lfsr[9:0], lfsr}),
           lfsr[3] & lfsr[8] & lfsr[11],
           {lfsr[4] & lfsr[9], lfsr[5] & lfsr[14], lfsr[6] & lfsr[12],
            lfsr[7] & lfsr[15], lfsr[2] & lfsr[10]},
           (i % 2 == 0) ? "R2" : "R5");
    end

    // R1: asynchronous reset mid-cycle
    for (int i = 0; i < NS; i++) step(mk(OPC, 26'h0), 1'b0, '0, "R6");
    #0.5 rst_n = 1'b0;
    exp_tok = '0;
    #0.2;
    check("R1");
    step(mk(OPC, 26'h0), 1'b0, '0, "R1");
    #1 rst_n = 1'b1;
    step(mk(OPC, 26'h0), 1'b0, '0, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule